// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit sits at the instruction boundary of a processor pipeline. When the pipeline raises `eval_i`, it compares the highest pending interrupt level with the level the core currently masks at. It also checks that the level has at least one interrupt line that is both set and enabled. If the interrupt is accepted, then on the next clock edge the unit does four things: it stores the return PC and, where needed, the old status word in its save bank; it rewrites the status word; it produces the vector address; and it raises a one-cycle `taken_o` strobe.

Levels above 1 each have their own PC/status save pair and their own vector. A level-1 interrupt is not dispatched directly. It is turned into a general exception: kernel, user or double, chosen from the status bits. The exception cause is then loaded with a fixed code. Vector targets can optionally be moved by a runtime base register.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `taken_o` is 0 and `next_pc_o`, `ps_o`, `exccause_o`, `kind_o`, every `epc_o`/`eps_o` slot and `depc_o` are all zero.
- R2: Status word layout: bits [3:0] hold the interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. With the exception-mode flag clear, a pending level L is accepted only when L is greater than bits [3:0].
- R3: With the exception-mode flag set, the current level is the larger of bits [3:0] and the parameter EXCM_LEVEL, and L must exceed it to be accepted.
- R4: A pending level of 0 or above NLEVEL is never accepted.
- R5: Level L owns the mask slice `level_mask_i[(L-1)*MASK_W +: MASK_W]`. L is accepted only if the AND of that slice, `int_set_i` and `int_en_i` is nonzero.
- R6: For an accepted L > 1, the unit sets `kind_o`=0 (high). Slot L-1 of `epc_o` receives `pc_i`, and slot L-1 of `eps_o` receives `ps_i`. `ps_o` equals `ps_i` with bits [3:0] replaced by L and bit 4 set. `next_pc_o` is the level-L vector, DEF_VECBASE + L*VEC_STRIDE.
- R7: For an accepted L = 1 with the exception-mode flag clear, slot 0 of `epc_o` receives `pc_i` and `exccause_o` is loaded with L1_CAUSE. `kind_o` is 2 (user) when bit 5 is set and 1 (kernel) otherwise, and the vector is DEF_VECBASE+USER_OFS or DEF_VECBASE+KERNEL_OFS respectively. `ps_o` is `ps_i` with bit 4 set.
- R8: For an accepted L = 1 with the exception-mode flag set, `kind_o` is 3 (double), `exccause_o` is L1_CAUSE and the vector is DEF_VECBASE+DOUBLE_OFS. `pc_i` goes to `depc_o` when HAS_DEPC=1, and to slot 0 of `epc_o` otherwise. The other of those two registers keeps its value.
- R9: With RELOC_EN=1, `next_pc_o` is the fixed vector minus DEF_VECBASE plus `vecbase_i`. With RELOC_EN=0, it is the fixed vector.
- R10: `taken_o` is high for exactly the one cycle after an accepted `eval_i`. A rejected or absent evaluation leaves every output and save register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Instruction-boundary evaluation request |
| pend_level_i | input | 4 | Highest pending interrupt level |
| ps_i | input | 32 | Current status word |
| int_set_i | input | MASK_W | Pending interrupt lines |
| int_en_i | input | MASK_W | Interrupt enable mask |
| level_mask_i | input | NLEVEL*MASK_W | Per-level line masks, level L in slice L-1 |
| pc_i | input | 32 | PC of the interrupted instruction |
| vecbase_i | input | 32 | Runtime vector base |
| taken_o | output | 1 | Dispatch strobe |
| kind_o | output | 2 | 0 high, 1 kernel, 2 user, 3 double |
| next_pc_o | output | 32 | Vector target |
| ps_o | output | 32 | Updated status word |
| exccause_o | output | CAUSE_W | Exception cause |
| epc_o | output | NLEVEL*32 | PC save registers, level L in slice L-1 |
| eps_o | output | NLEVEL*32 | Status save registers, level L in slice L-1 (slot 0 unused) |
| depc_o | output | 32 | Double-exception PC save |

## Verification
The bench builds three copies of the block with identical inputs.

- The first copy uses the defaults: six levels, EXCM_LEVEL=3, a double-exception PC register, and relocation on. This copy exercises level comparison, the raised floor while exception mode is set, the mask path and the relocated high-level and general vectors.
- A level-1 interrupt with exception mode set can only be accepted when EXCM_LEVEL is 0, so the other two copies use EXCM_LEVEL=0. Both have relocation off: one keeps the dedicated double-exception PC register and the other drops it. Between them, both save targets of the double exception and the unrelocated vectors become reachable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IL_W      = 4;
  localparam int PS_EXCM_B = 4;
  localparam int PS_UM_B   = 5;

  typedef enum logic [1:0] {
    KIND_HIGH   = 2'd0,
    KIND_KERNEL = 2'd1,
    KIND_USER   = 2'd2,
    KIND_DOUBLE = 2'd3
  } irq_kind_e;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_pkg::*;
#(
  parameter int NLEVEL     = 6,
  parameter int MASK_W     = 32,
  parameter int EXCM_LEVEL = 3
) (
  input  logic [IL_W-1:0]          level_i,
  input  logic [31:0]              ps_i,
  input  logic [MASK_W-1:0]        int_set_i,
  input  logic [MASK_W-1:0]        int_en_i,
  input  logic [NLEVEL*MASK_W-1:0] level_mask_i,
  output logic                     accept_o
);
  localparam logic [IL_W-1:0] EXCM_LVL = IL_W'(EXCM_LEVEL);

  logic [NLEVEL-1:0] hit;
  logic [IL_W-1:0]   cur_level;
  logic              sel_hit;
  logic              in_range;

  for (genvar l = 0; l < NLEVEL; l++) begin : g_hit
    assign hit[l] = |(level_mask_i[l*MASK_W +: MASK_W] & int_set_i & int_en_i);
  end

  always_comb begin
    cur_level = ps_i[IL_W-1:0];
    if (ps_i[PS_EXCM_B] && (EXCM_LVL > cur_level)) cur_level = EXCM_LVL;
  end

  always_comb begin
    sel_hit = 1'b0;
    for (int l = 1; l <= NLEVEL; l++)
      if (level_i == IL_W'(l)) sel_hit = hit[l-1];
  end

  assign in_range = (level_i != '0) && (level_i <= IL_W'(NLEVEL));
  assign accept_o = in_range && (level_i > cur_level) && sel_hit;
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_pkg::*;
#(
  parameter int          NLEVEL      = 6,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] VEC_STRIDE  = 32'h40,
  parameter logic [31:0] KERNEL_OFS  = 32'h300,
  parameter logic [31:0] USER_OFS    = 32'h340,
  parameter logic [31:0] DOUBLE_OFS  = 32'h3C0,
  parameter bit          RELOC_EN    = 1'b1
) (
  input  logic [IL_W-1:0] level_i,
  input  irq_kind_e       kind_i,
  input  logic [31:0]     vecbase_i,
  output logic [31:0]     vec_o
);
  logic [31:0] fixed_vec;

  always_comb begin
    unique case (kind_i)
      KIND_HIGH:   fixed_vec = DEF_VECBASE + 32'(level_i) * VEC_STRIDE;
      KIND_KERNEL: fixed_vec = DEF_VECBASE + KERNEL_OFS;
      KIND_USER:   fixed_vec = DEF_VECBASE + USER_OFS;
      default:     fixed_vec = DEF_VECBASE + DOUBLE_OFS;
    endcase
  end

  if (RELOC_EN) begin : g_reloc
    assign vec_o = fixed_vec - DEF_VECBASE + vecbase_i;
  end else begin : g_fixed
    assign vec_o = fixed_vec;
  end
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_pkg::*;
#(
  parameter int NLEVEL   = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IL_W-1:0]      level_i,
  input  irq_kind_e            kind_i,
  input  logic [31:0]          pc_i,
  input  logic [31:0]          ps_i,
  output logic [NLEVEL*32-1:0] epc_o,
  output logic [NLEVEL*32-1:0] eps_o,
  output logic [31:0]          depc_o
);
  logic high_wr, gen_wr, dbl_to_depc;

  assign high_wr     = wr_i && (kind_i == KIND_HIGH);
  assign dbl_to_depc = HAS_DEPC && (kind_i == KIND_DOUBLE);
  assign gen_wr      = wr_i && (kind_i != KIND_HIGH) && !dbl_to_depc;

  for (genvar l = 1; l <= NLEVEL; l++) begin : g_lvl
    logic epc_we;
    if (l == 1) begin : g_l1
      assign epc_we = gen_wr;
      assign eps_o[31:0] = '0;
    end else begin : g_hi
      assign epc_we = high_wr && (level_i == IL_W'(l));
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)     eps_o[(l-1)*32 +: 32] <= '0;
        else if (epc_we) eps_o[(l-1)*32 +: 32] <= ps_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)     epc_o[(l-1)*32 +: 32] <= '0;
      else if (epc_we) epc_o[(l-1)*32 +: 32] <= pc_i;
  end

  if (HAS_DEPC) begin : g_depc
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                  depc_o <= '0;
      else if (wr_i && dbl_to_depc) depc_o <= pc_i;
  end else begin : g_no_depc
    assign depc_o = '0;
  end

  // R10: save registers only move on a dispatch
  p_bank_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(epc_o) && $stable(eps_o) && $stable(depc_o)));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int          NLEVEL      = 6,
  parameter int          MASK_W      = 32,
  parameter int          EXCM_LEVEL  = 3,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter bit          RELOC_EN    = 1'b1,
  parameter int          CAUSE_W     = 6,
  parameter int          L1_CAUSE    = 4,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] VEC_STRIDE  = 32'h40,
  parameter logic [31:0] KERNEL_OFS  = 32'h300,
  parameter logic [31:0] USER_OFS    = 32'h340,
  parameter logic [31:0] DOUBLE_OFS  = 32'h3C0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     eval_i,
  input  logic [3:0]               pend_level_i,
  input  logic [31:0]              ps_i,
  input  logic [MASK_W-1:0]        int_set_i,
  input  logic [MASK_W-1:0]        int_en_i,
  input  logic [NLEVEL*MASK_W-1:0] level_mask_i,
  input  logic [31:0]              pc_i,
  input  logic [31:0]              vecbase_i,
  output logic                     taken_o,
  output logic [1:0]               kind_o,
  output logic [31:0]              next_pc_o,
  output logic [31:0]              ps_o,
  output logic [CAUSE_W-1:0]       exccause_o,
  output logic [NLEVEL*32-1:0]     epc_o,
  output logic [NLEVEL*32-1:0]     eps_o,
  output logic [31:0]              depc_o
);
  logic        accept, wr;
  irq_kind_e   kind_d;
  logic [31:0] ps_d, vec_d;

  irq_accept #(.NLEVEL(NLEVEL), .MASK_W(MASK_W), .EXCM_LEVEL(EXCM_LEVEL)) u_accept (
    .level_i(pend_level_i), .ps_i(ps_i), .int_set_i(int_set_i),
    .int_en_i(int_en_i), .level_mask_i(level_mask_i), .accept_o(accept)
  );

  always_comb begin
    if (pend_level_i > 4'd1)    kind_d = KIND_HIGH;
    else if (ps_i[PS_EXCM_B])   kind_d = KIND_DOUBLE;
    else if (ps_i[PS_UM_B])     kind_d = KIND_USER;
    else                        kind_d = KIND_KERNEL;
  end

  always_comb begin
    ps_d = ps_i;
    if (kind_d == KIND_HIGH) ps_d[IL_W-1:0] = pend_level_i;
    ps_d[PS_EXCM_B] = 1'b1;
  end

  irq_vector #(
    .NLEVEL(NLEVEL), .DEF_VECBASE(DEF_VECBASE), .VEC_STRIDE(VEC_STRIDE),
    .KERNEL_OFS(KERNEL_OFS), .USER_OFS(USER_OFS), .DOUBLE_OFS(DOUBLE_OFS),
    .RELOC_EN(RELOC_EN)
  ) u_vector (
    .level_i(pend_level_i), .kind_i(kind_d), .vecbase_i(vecbase_i), .vec_o(vec_d)
  );

  assign wr = eval_i && accept;

  irq_save_bank #(.NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .level_i(pend_level_i),
    .kind_i(kind_d), .pc_i(pc_i), .ps_i(ps_i),
    .epc_o(epc_o), .eps_o(eps_o), .depc_o(depc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o    <= 1'b0;
      kind_o     <= '0;
      next_pc_o  <= '0;
      ps_o       <= '0;
      exccause_o <= '0;
    end else begin
      taken_o <= wr;
      if (wr) begin
        kind_o    <= kind_d;
        next_pc_o <= vec_d;
        ps_o      <= ps_d;
        if (kind_d != KIND_HIGH) exccause_o <= CAUSE_W'(L1_CAUSE);
      end
    end
  end

  p_taken_after_eval_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(eval_i));
  p_excm_on_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> ps_o[PS_EXCM_B]);
  p_high_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && kind_o == KIND_HIGH) |->
      (ps_o[IL_W-1:0] > 4'd1 && ps_o[IL_W-1:0] <= IL_W'(NLEVEL)));
  p_l1_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && kind_o != KIND_HIGH) |-> exccause_o == CAUSE_W'(L1_CAUSE));
  p_double_needs_excm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && kind_o == KIND_DOUBLE) |-> $past(ps_i[PS_EXCM_B]));
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;
  localparam int MW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eval = 1'b0;
  logic [3:0] lvl = '0;
  logic [31:0] ps = '0, pc = '0, vb = 32'h6000_0000;
  logic [MW-1:0] iset = '0, ien = '1;
  logic [NL*MW-1:0] lmask;

  logic taken_a, taken_b, taken_c;
  logic [1:0] kind_a, kind_b, kind_c;
  logic [31:0] npc_a, npc_b, npc_c, pso_a, pso_b, pso_c, depc_a, depc_b, depc_c;
  logic [5:0] cause_a, cause_b, cause_c;
  logic [NL*32-1:0] epc_a, epc_b, epc_c, eps_a, eps_b, eps_c;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar l = 0; l < NL; l++) begin : g_m
    assign lmask[l*MW +: MW] = 32'hF << (4*l);
  end

  irq_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .pend_level_i(lvl), .ps_i(ps),
    .int_set_i(iset), .int_en_i(ien), .level_mask_i(lmask), .pc_i(pc), .vecbase_i(vb),
    .taken_o(taken_a), .kind_o(kind_a), .next_pc_o(npc_a), .ps_o(pso_a),
    .exccause_o(cause_a), .epc_o(epc_a), .eps_o(eps_a), .depc_o(depc_a));

  irq_dispatch #(.EXCM_LEVEL(0), .HAS_DEPC(1'b1), .RELOC_EN(1'b0)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .pend_level_i(lvl), .ps_i(ps),
    .int_set_i(iset), .int_en_i(ien), .level_mask_i(lmask), .pc_i(pc), .vecbase_i(vb),
    .taken_o(taken_b), .kind_o(kind_b), .next_pc_o(npc_b), .ps_o(pso_b),
    .exccause_o(cause_b), .epc_o(epc_b), .eps_o(eps_b), .depc_o(depc_b));

  irq_dispatch #(.EXCM_LEVEL(0), .HAS_DEPC(1'b0), .RELOC_EN(1'b0)) uut_c (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .pend_level_i(lvl), .ps_i(ps),
    .int_set_i(iset), .int_en_i(ien), .level_mask_i(lmask), .pc_i(pc), .vecbase_i(vb),
    .taken_o(taken_c), .kind_o(kind_c), .next_pc_o(npc_c), .ps_o(pso_c),
    .exccause_o(cause_c), .epc_o(epc_c), .eps_o(eps_c), .depc_o(depc_c));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one evaluation, return at the next falling edge with outputs settled
  task automatic fire(logic [3:0] l, logic [31:0] p, logic [31:0] s, logic [31:0] e, logic [31:0] a);
    @(negedge clk);
    lvl = l; ps = p; iset = s; ien = e; pc = a; eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 taken", 32'(taken_a), 0);
    chk("R1 next_pc", npc_a, 0);
    chk("R1 ps", pso_a, 0);
    chk("R1 cause", 32'(cause_a), 0);
    chk("R1 kind", 32'(kind_a), 0);
    chk("R1 epc", 32'(|epc_a), 0);
    chk("R1 eps", 32'(|eps_a), 0);
    chk("R1 depc", depc_a, 0);
  endtask

  task automatic t_high();
    fire(4'd3, 32'h0000_0021, 32'h0000_0100, '1, 32'h1000_0010);
    chk("R6 taken", 32'(taken_a), 1);
    chk("R6 kind", 32'(kind_a), 0);
    chk("R6 epc3", epc_a[2*32 +: 32], 32'h1000_0010);
    chk("R6 eps3", eps_a[2*32 +: 32], 32'h0000_0021);
    chk("R6 ps", pso_a, 32'h0000_0033);
    chk("R9 reloc vector", npc_a, 32'h6000_00C0);
    chk("R9 fixed vector", npc_b, 32'h4000_00C0);
    @(negedge clk);
    chk("R10 pulse", 32'(taken_a), 0);
  endtask

  task automatic t_level_cmp();
    fire(4'd4, 32'h0000_0004, 32'h0000_F000, '1, 32'h1000_0020);
    chk("R2 equal level rejected", 32'(taken_a), 0);
    chk("R10 ps held", pso_a, 32'h0000_0033);
    chk("R10 epc4 held", epc_a[3*32 +: 32], 0);
    fire(4'd5, 32'h0000_0004, 32'h000F_0000, '1, 32'h1000_0024);
    chk("R2 higher level taken", 32'(taken_a), 1);
    chk("R2 epc5", epc_a[4*32 +: 32], 32'h1000_0024);
  endtask

  task automatic t_excm_floor();
    fire(4'd3, 32'h0000_0011, 32'h0000_0F00, '1, 32'h1000_0030);
    chk("R3 at floor rejected", 32'(taken_a), 0);
    chk("R3 epc3 held", epc_a[2*32 +: 32], 32'h1000_0010);
    fire(4'd4, 32'h0000_0011, 32'h0000_F000, '1, 32'h1000_0034);
    chk("R3 above floor taken", 32'(taken_a), 1);
    chk("R3 ps", pso_a, 32'h0000_0014);
    chk("R3 eps4", eps_a[3*32 +: 32], 32'h0000_0011);
  endtask

  task automatic t_range();
    fire(4'd7, 32'h0, '1, '1, 32'h1000_0040);
    chk("R4 level above NLEVEL", 32'(taken_a), 0);
    fire(4'd0, 32'h0, '1, '1, 32'h1000_0044);
    chk("R4 level zero", 32'(taken_a), 0);
    fire(4'd6, 32'h0, 32'h00F0_0000, '1, 32'h1000_0048);
    chk("R4 top level taken", 32'(taken_a), 1);
    chk("R4 vector 6", npc_a, 32'h6000_0180);
  endtask

  task automatic t_mask();
    fire(4'd5, 32'h0, 32'h0000_00F0, '1, 32'h1000_0050);
    chk("R5 other level bits", 32'(taken_a), 0);
    fire(4'd5, 32'h0, 32'h0001_0000, 32'hFFFE_FFFF, 32'h1000_0054);
    chk("R5 disabled line", 32'(taken_a), 0);
    chk("R5 epc5 held", epc_a[4*32 +: 32], 32'h1000_0024);
  endtask

  task automatic t_level1();
    fire(4'd1, 32'h0, 32'h1, '1, 32'h2000_0000);
    chk("R7 kernel kind", 32'(kind_a), 1);
    chk("R7 epc1", epc_a[31:0], 32'h2000_0000);
    chk("R7 cause", 32'(cause_a), 4);
    chk("R7 kernel vector", npc_a, 32'h6000_0300);
    chk("R7 ps", pso_a, 32'h0000_0010);
    fire(4'd1, 32'h0000_0020, 32'h1, '1, 32'h2000_0004);
    chk("R7 user kind", 32'(kind_a), 2);
    chk("R7 user vector", npc_a, 32'h6000_0340);
    chk("R7 user ps", pso_a, 32'h0000_0030);
  endtask

  task automatic t_double();
    logic [31:0] epc1_b;
    logic [31:0] depc_before_c;
    epc1_b = epc_b[31:0];
    depc_before_c = depc_c;
    fire(4'd1, 32'h0000_0010, 32'h1, '1, 32'h3000_0000);
    chk("R3 default floor blocks level1", 32'(taken_a), 0);
    chk("R8 kind", 32'(kind_b), 3);
    chk("R8 cause", 32'(cause_b), 4);
    chk("R8 depc", depc_b, 32'h3000_0000);
    chk("R8 epc1 kept", epc_b[31:0], epc1_b);
    chk("R8 vector", npc_b, 32'h4000_03C0);
    chk("R8 no depc epc1", epc_c[31:0], 32'h3000_0000);
    chk("R8 no depc reg", depc_c, depc_before_c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_high();
    t_level_cmp();
    t_excm_floor();
    t_range();
    t_mask();
    t_level1();
    t_double();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule